// File: doc/BRIEF.md
# Eight-Channel Converter Control Sequencer

This block is the digital control front-end of an eight-channel analog-to-digital converter. Software reaches it over a simple 32-bit register bus. There are two registers: a control/status word at word index 0 and a result word at word index 1. The sampled channel values and the two candidate reference levels arrive as unsigned words on input ports. From these the block computes a saturating 10-bit ratiometric result.

A conversion is launched from the control word. Its length is 20 converter cycles, and one converter cycle is a programmable number of input clocks. During that time a sequential divider forms the result. When the conversion ends, the block stores the result, clears the busy bit and, if enabled, latches an interrupt flag that drives a level interrupt. The same control word also carries a soft-reset request. That request, after 10 converter cycles, returns both registers to their power-up values. An out-of-range channel number completes harmlessly with a zero result and a one-cycle error pulse.

Top module: `adc_seq_top`

## Requirements
- R1: After rst_ni deasserts, the control word reads 0x000C0001, the result word reads 0 and irq_o is low.
- R2: Word index 0 (bus_addr_i=0) is the control word and index 1 is the read-only result word. Writes to index 1 change neither register. Control fields: channel select [27:24], interrupt enable [21], reference select [19], interrupt flag [18], enable [17], soft-reset request [16], busy/convert [14], divider [8:1].
- R3: A conversion starts on a control write with enable=1 whose convert bit is 1 while the stored bit is 0. Let D be the written divider. The convert bit reads 1 until, and clears at, the clock edge 2*(D+1)*20 cycles after the write edge.
- R4: The result is floor(input*1024/reference), clamped to 1023. A zero reference gives 1023. The result is zero-extended into the result word at completion.
- R5: Reference select 1 uses int_ref_i and 0 uses ext_ref_i. The reference and the selected channel are sampled at the start of the conversion.
- R6: Writing 1 to the flag bit clears it. Writing 0 leaves it unchanged.
- R7: At completion with interrupt enable set, the flag sets. irq_o equals flag AND interrupt enable. With interrupt enable clear, completion leaves the flag unchanged.
- R8: A control write with enable=1 and convert=0 during a conversion aborts it: the result word keeps its old value.
- R9: A 0-to-1 write of the soft-reset bit (divider D) restores both registers to their reset values at the edge 2*(D+1)*10 cycles after the write edge. Before that edge they are unchanged.
- R10: Writing the soft-reset bit to 0 before expiry cancels the soft reset.
- R11: A channel select of 8 to 15 completes normally with result 0. bad_chan_o is high for exactly the one cycle after the completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 1 | Word index: 0 control, 1 result |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| chan_i | input | NCH*IN_W | Sampled channel values, channel i at bits [i*IN_W +: IN_W] |
| int_ref_i | input | IN_W | Internal reference level |
| ext_ref_i | input | IN_W | External reference level |
| irq_o | output | 1 | Level interrupt |
| bad_chan_o | output | 1 | One-cycle pulse after an out-of-range conversion |

## Verification
Every result is tied to the write edge that caused it. A conversion is due exactly 40*(D+1) cycles after that edge, and a soft reset 20*(D+1) cycles after it. The error pulse is due one cycle later and lasts a single cycle. irq_o and read data follow the registers with no added delay. The bench drives on falling edges and counts falling edges from the write. It samples once in the cycle before each due edge to confirm nothing has changed yet, and once in the cycle after it to confirm the update. Aborts and cancels are checked well past the edge where the action would have landed.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned RES_W    = 10;
  localparam int unsigned SEL_LSB  = 24;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned IEN_BIT  = 21;
  localparam int unsigned RSEL_BIT = 19;
  localparam int unsigned FLAG_BIT = 18;
  localparam int unsigned EN_BIT   = 17;
  localparam int unsigned SRST_BIT = 16;
  localparam int unsigned CONV_BIT = 14;
  localparam int unsigned DIV_LSB  = 1;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned PSC_W    = DIV_W + 2;
  localparam logic [REG_W-1:0] CTRL_RST = 32'h000C_0001;
endpackage

// File: rtl/adc_seq_timer.sv
`timescale 1ns/1ps
// Counts CYC converter cycles of psc input clocks each; done_o marks the last clock.
module adc_seq_timer #(
  parameter int unsigned CYC   = 20,
  parameter int unsigned PSC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cancel_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             done_o
);
  localparam int unsigned CNT_W = (CYC > 1) ? $clog2(CYC) : 1;

  logic             busy_q;
  logic [PSC_W-1:0] psc_q, pre_q;
  logic [CNT_W-1:0] cyc_q;
  logic             pre_last, cyc_last;

  assign pre_last = (pre_q == psc_q - PSC_W'(1));
  assign cyc_last = (cyc_q == CNT_W'(CYC - 1));
  assign done_o   = busy_q & pre_last & cyc_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      psc_q  <= PSC_W'(2);
      pre_q  <= '0;
      cyc_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      psc_q  <= psc_i;
      pre_q  <= '0;
      cyc_q  <= '0;
    end else if (cancel_i) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (pre_last) begin
        pre_q <= '0;
        if (cyc_last) busy_q <= 1'b0;
        else          cyc_q  <= cyc_q + CNT_W'(1);
      end else begin
        pre_q <= pre_q + PSC_W'(1);
      end
    end
  end
endmodule

// File: rtl/adc_seq_div.sv
`timescale 1ns/1ps
// Restoring divider: res = min(floor(num*2^RES_W/den), 2^RES_W-1), RES_W+1 cycles.
module adc_seq_div #(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IN_W-1:0]  num_i,
  input  logic [IN_W-1:0]  den_i,
  output logic             valid_o,
  output logic [RES_W-1:0] res_o
);
  localparam int unsigned CNT_W = $clog2(RES_W + 1);

  logic [IN_W:0]      rem_q, rem_sh;
  logic [IN_W-1:0]    den_q;
  logic [RES_W-1:0]   quo_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q, valid_q;
  logic               fits;

  assign rem_sh  = {rem_q[IN_W-1:0], 1'b0};
  assign fits    = (rem_sh >= {1'b0, den_q});
  assign valid_o = valid_q;
  assign res_o   = quo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      if (den_i == '0 || num_i >= den_i) begin
        quo_q   <= '1;
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
      end else begin
        rem_q   <= {1'b0, num_i};
        den_q   <= den_i;
        quo_q   <= '0;
        cnt_q   <= CNT_W'(RES_W);
        busy_q  <= 1'b1;
        valid_q <= 1'b0;
      end
    end else if (busy_q) begin
      rem_q <= fits ? rem_sh - {1'b0, den_q} : rem_sh;
      quo_q <= {quo_q[RES_W-2:0], fits};
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int unsigned NCH      = 8,
  parameter int unsigned IN_W     = 24,
  parameter int unsigned CONV_CYC = 20,
  parameter int unsigned RST_CYC  = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic                bus_addr_i,
  input  logic [REG_W-1:0]    bus_wdata_i,
  output logic [REG_W-1:0]    bus_rdata_o,
  input  logic [NCH*IN_W-1:0] chan_i,
  input  logic [IN_W-1:0]     int_ref_i,
  input  logic [IN_W-1:0]     ext_ref_i,
  output logic                irq_o,
  output logic                bad_chan_o
);
  logic [REG_W-1:0] con_q, con_nxt, data_q, wval;
  logic             wr_con;
  logic [SEL_W-1:0] sel_w;
  logic [PSC_W-1:0] psc_w;
  logic [IN_W-1:0]  num_sel, ref_sel, samp_ref;
  logic             bad_sel, bad_q, bad_pulse_q;
  logic             conv_start, conv_abort, conv_done;
  logic             srst_start, srst_abort, srst_done;
  logic             div_valid;
  logic [RES_W-1:0] div_res;

  assign wr_con = bus_req_i & bus_we_i & ~bus_addr_i;
  assign sel_w  = bus_wdata_i[SEL_LSB +: SEL_W];
  assign psc_w  = {({1'b0, bus_wdata_i[DIV_LSB +: DIV_W]} + (DIV_W+1)'(1)), 1'b0};

  assign conv_start = wr_con & bus_wdata_i[EN_BIT] & bus_wdata_i[CONV_BIT] & ~con_q[CONV_BIT];
  assign conv_abort = wr_con & bus_wdata_i[EN_BIT] & ~bus_wdata_i[CONV_BIT];
  assign srst_start = wr_con & bus_wdata_i[SRST_BIT] & ~con_q[SRST_BIT];
  assign srst_abort = wr_con & ~bus_wdata_i[SRST_BIT];

  // channel mux; out-of-range selects give zero
  always_comb begin
    num_sel = '0;
    for (int i = 0; i < int'(NCH); i++) begin
      if (sel_w == SEL_W'(i)) num_sel = chan_i[i*IN_W +: IN_W];
    end
  end
  assign bad_sel = (32'(sel_w) >= NCH);
  assign ref_sel = bus_wdata_i[RSEL_BIT] ? int_ref_i : ext_ref_i;

  // write value with write-1-to-clear flag
  always_comb begin
    wval           = bus_wdata_i;
    wval[FLAG_BIT] = bus_wdata_i[FLAG_BIT] ? 1'b0 : con_q[FLAG_BIT];
  end

  always_comb begin
    con_nxt = wr_con ? wval : con_q;
    if (conv_done) begin
      con_nxt[CONV_BIT] = 1'b0;
      if (con_q[IEN_BIT]) con_nxt[FLAG_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      con_q  <= CTRL_RST;
      data_q <= '0;
    end else if (srst_done) begin
      con_q  <= CTRL_RST;
      data_q <= '0;
    end else begin
      con_q <= con_nxt;
      if (conv_done) data_q <= bad_q ? '0 : REG_W'(div_res);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bad_q       <= 1'b0;
      samp_ref    <= '0;
      bad_pulse_q <= 1'b0;
    end else begin
      if (conv_start) begin
        bad_q    <= bad_sel;
        samp_ref <= ref_sel;
      end
      bad_pulse_q <= conv_done & ~srst_done & bad_q;
    end
  end

  adc_seq_timer #(.CYC(CONV_CYC), .PSC_W(PSC_W)) u_conv_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (conv_start),
    .cancel_i (conv_abort | srst_done),
    .psc_i    (psc_w),
    .done_o   (conv_done)
  );

  adc_seq_timer #(.CYC(RST_CYC), .PSC_W(PSC_W)) u_srst_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (srst_start),
    .cancel_i (srst_abort),
    .psc_i    (psc_w),
    .done_o   (srst_done)
  );

  adc_seq_div #(.IN_W(IN_W), .RES_W(RES_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (conv_start),
    .num_i   (num_sel),
    .den_i   (ref_sel),
    .valid_o (div_valid),
    .res_o   (div_res)
  );

  assign bus_rdata_o = bus_addr_i ? data_q : con_q;
  assign irq_o       = con_q[FLAG_BIT] & con_q[IEN_BIT];
  assign bad_chan_o  = bad_pulse_q;
endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int unsigned IN_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] con_q,
  input logic [REG_W-1:0] data_q,
  input logic             conv_done,
  input logic             srst_done,
  input logic             div_valid,
  input logic [RES_W-1:0] div_res,
  input logic [IN_W-1:0]  samp_ref,
  input logic             bad_chan_o
);
  p_div_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done |-> div_valid);

  p_zero_ref_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done && samp_ref == '0) |-> (div_res == '1));

  p_conv_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done && !srst_done) |=> !con_q[CONV_BIT]);

  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done && !srst_done && con_q[IEN_BIT]) |=> con_q[FLAG_BIT]);

  p_bad_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_chan_o |=> !bad_chan_o);

  p_soft_restore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_done |=> (con_q == CTRL_RST && data_q == '0));
endmodule

bind adc_seq_top adc_seq_chk #(.IN_W(IN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .con_q      (con_q),
  .data_q     (data_q),
  .conv_done  (conv_done),
  .srst_done  (srst_done),
  .div_valid  (div_valid),
  .div_res    (div_res),
  .samp_ref   (samp_ref),
  .bad_chan_o (bad_chan_o)
);

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;
  localparam int NCH = 8;
  localparam int IN_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [IN_W-1:0] ch_v [NCH];
  logic [NCH*IN_W-1:0] chan;
  logic [IN_W-1:0] int_ref, ext_ref;
  logic irq, bad;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) chan[i*IN_W +: IN_W] = ch_v[i];
  end

  adc_seq_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .chan_i(chan), .int_ref_i(int_ref), .ext_ref_i(ext_ref),
    .irq_o(irq), .bad_chan_o(bad)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic get(input logic a, output logic [31:0] v);
    addr = a;
    #0.1;
    v = rdata;
  endtask

  function automatic logic [31:0] mk(int ch, bit ie, bit rs, bit fl, bit en, bit sr, bit cv, int dv);
    logic [31:0] v = '0;
    v[27:24] = 4'(ch); v[21] = ie; v[19] = rs; v[18] = fl;
    v[17] = en; v[16] = sr; v[14] = cv; v[8:1] = 8'(dv);
    return v;
  endfunction

  function automatic logic [31:0] ratio(longint in, longint rf);
    if (rf == 0 || in >= rf) return 32'd1023;
    return 32'((in * 1024) / rf);
  endfunction

  logic [31:0] v;

  task automatic t_reset();
    get(1'b0, v); chk("R1 control", v, 32'h000C_0001);
    get(1'b1, v); chk("R1 data", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_conv_int();
    logic [31:0] c;
    bus_wr(1'b0, mk(0, 0, 0, 1, 0, 0, 0, 0));
    get(1'b0, v); chk("R6 flag cleared by 1", v, 32'h0);
    c = mk(3, 1, 1, 0, 1, 0, 1, 0);
    bus_wr(1'b0, c);
    wait_n(39);
    get(1'b0, v); chk("R3 busy before due edge", {31'b0, v[14]}, 32'h1);
    chk("R7 irq low while busy", {31'b0, irq}, 32'h0);
    wait_n(1);
    get(1'b1, v); chk("R4 R5 internal ref result", v, ratio(ch_v[3], int_ref));
    get(1'b0, v); chk("R3 R7 control after completion", v, mk(3, 1, 1, 1, 1, 0, 0, 0));
    chk("R7 irq high", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_w1c();
    bus_wr(1'b0, mk(3, 1, 1, 0, 1, 0, 0, 0));
    get(1'b0, v); chk("R6 write 0 keeps flag", v, mk(3, 1, 1, 1, 1, 0, 0, 0));
    chk("R7 irq stays", {31'b0, irq}, 32'h1);
    bus_wr(1'b0, mk(3, 1, 1, 1, 1, 0, 0, 0));
    get(1'b0, v); chk("R6 write 1 clears flag", v, mk(3, 1, 1, 0, 1, 0, 0, 0));
    chk("R7 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ext_div();
    bus_wr(1'b0, mk(7, 0, 0, 0, 1, 0, 1, 2));
    wait_n(119);
    get(1'b0, v); chk("R3 busy at divider 2", {31'b0, v[14]}, 32'h1);
    wait_n(1);
    get(1'b1, v); chk("R5 external ref result", v, ratio(ch_v[7], ext_ref));
    get(1'b0, v); chk("R7 no flag without enable", v, mk(7, 0, 0, 0, 1, 0, 0, 2));
    chk("R7 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_sat();
    ext_ref = 24'd500000;
    bus_wr(1'b0, mk(7, 0, 0, 0, 1, 0, 1, 0));
    wait_n(40);
    get(1'b1, v); chk("R4 clamp input above ref", v, 32'd1023);
    int_ref = '0;
    bus_wr(1'b0, mk(0, 0, 1, 0, 1, 0, 1, 0));
    wait_n(40);
    get(1'b1, v); chk("R4 zero reference", v, 32'd1023);
    int_ref = 24'd2000000;
    ext_ref = 24'd1000000;
  endtask

  task automatic t_abort();
    bus_wr(1'b0, mk(3, 0, 1, 0, 1, 0, 1, 0));
    wait_n(10);
    bus_wr(1'b0, mk(3, 0, 1, 0, 1, 0, 0, 0));
    wait_n(60);
    get(1'b1, v); chk("R8 aborted result untouched", v, 32'd1023);
    get(1'b0, v); chk("R8 control after abort", v, mk(3, 0, 1, 0, 1, 0, 0, 0));
  endtask

  task automatic t_bad();
    bus_wr(1'b0, mk(9, 0, 1, 0, 1, 0, 1, 0));
    wait_n(39);
    chk("R11 no pulse early", {31'b0, bad}, 32'h0);
    wait_n(1);
    chk("R11 pulse", {31'b0, bad}, 32'h1);
    get(1'b1, v); chk("R11 zero result", v, 32'h0);
    get(1'b0, v); chk("R11 R3 busy cleared", {31'b0, v[14]}, 32'h0);
    wait_n(1);
    chk("R11 pulse one cycle", {31'b0, bad}, 32'h0);
  endtask

  task automatic t_data_ro();
    bus_wr(1'b0, mk(3, 0, 1, 0, 1, 0, 1, 0));
    wait_n(40);
    bus_wr(1'b1, 32'hFFFF_FFFF);
    get(1'b1, v); chk("R2 result word read-only", v, ratio(ch_v[3], int_ref));
    get(1'b0, v); chk("R2 control untouched", v, mk(3, 0, 1, 0, 1, 0, 0, 0));
  endtask

  task automatic t_srst_cancel();
    bus_wr(1'b0, mk(3, 0, 1, 0, 1, 1, 0, 1));
    wait_n(5);
    bus_wr(1'b0, mk(3, 0, 1, 0, 1, 0, 0, 1));
    wait_n(60);
    get(1'b0, v); chk("R10 cancelled control", v, mk(3, 0, 1, 0, 1, 0, 0, 1));
    get(1'b1, v); chk("R10 cancelled data", v, ratio(ch_v[3], int_ref));
  endtask

  task automatic t_srst();
    bus_wr(1'b0, mk(3, 0, 1, 0, 1, 1, 0, 1));
    wait_n(39);
    get(1'b0, v); chk("R9 control before expiry", v, mk(3, 0, 1, 0, 1, 1, 0, 1));
    get(1'b1, v); chk("R9 data before expiry", v, ratio(ch_v[3], int_ref));
    wait_n(1);
    get(1'b0, v); chk("R9 control restored", v, 32'h000C_0001);
    get(1'b1, v); chk("R9 data restored", v, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) ch_v[i] = IN_W'(100000 * (i + 1));
    int_ref = 24'd2000000;
    ext_ref = 24'd1000000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_conv_int();
    t_w1c();
    t_ext_div();
    t_sat();
    t_abort();
    t_bad();
    t_data_ro();
    t_srst_cancel();
    t_srst();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule